// File: doc/BRIEF.md
# Strobed Column Output Latch with Blanking

This block holds the column pattern that a display column driver presents to its high-voltage output stage. A wide parallel word arrives from the loading register. Each system clock edge at which the active-low strobe is seen asserted copies that word into a holding store. While the strobe stays asserted across several edges, the store follows the word edge by edge, so the latch is transparent. Once the strobe is released, the store keeps its last value.

Two global overrides sit between the store and the outputs. A blanking input drives every output low and takes precedence over everything else. A force input drives every output high when blanking is inactive. The overrides act only on the output vector. The stored pattern survives them and reappears as soon as both overrides are released.

In the single-ended bus modes only the primary strobe pin matters. In the dual-edge differential mode the strobe is a complementary pair. It counts as asserted only when the primary pin is low and its partner is high. The strobe is sampled in the system clock domain, so it must be low for at least one rising edge to take effect.

Top module: `pdp_col_latch`

## Requirements
- R1: A clock edge with `rst_n` low clears the stored pattern to all zeros, so `col_out` reads zero once the overrides are inactive.
- R2: When the strobe is asserted at a rising edge, `col_data` at that edge is stored and appears on `col_out` right after that edge, provided `blank_n` and `hv_force_n` are both 1.
- R3: While the strobe stays asserted over consecutive edges, `col_out` follows `col_data` anew after every edge.
- R4: At an edge where the strobe is not asserted, the stored pattern is unchanged, whatever `col_data` does.
- R5: When `blank_n` is 0, every bit of `col_out` is 0, whatever the other inputs are.
- R6: When `blank_n` is 1 and `hv_force_n` is 0, every bit of `col_out` is 1.
- R7: The stored pattern is visible on `col_out` only while both `blank_n` and `hv_force_n` are 1.
- R8: The overrides do not alter the store. A capture made while an override is active is kept, and it appears once the overrides are released.
- R9: With `mode_dual` = 0, the strobe is asserted exactly when `stb_n` is 0, and `stb_pair` has no effect.
- R10: With `mode_dual` = 1, the strobe is asserted only when `stb_n` = 0 and `stb_pair` = 1. The combinations (0,0), (1,1) and (1,0) leave the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_dual | input | 1 | 1 selects the differential dual-edge strobe pairing |
| col_data | input | WIDTH | Parallel word from the loading register |
| stb_n | input | 1 | Active-low strobe (primary pin of the pair) |
| stb_pair | input | 1 | Complementary strobe pin, used only when mode_dual = 1 |
| blank_n | input | 1 | Active-low blanking: forces all outputs low |
| hv_force_n | input | 1 | Active-low force: drives all outputs high when not blanked |
| col_out | output | WIDTH | Column output vector to the drive stage |

## Verification
The bench sweeps every combination of mode, both strobe pins, blanking and force, and loads a fresh data word at each step. The corner cases are these:
- A decoder that ignored the partner pin in differential mode would capture on the invalid (0,0) pair.
- A decoder that consulted the partner pin in single-ended mode would miss a strobe or add one.
- A swapped override priority would drive the outputs high while blanked.
- An override that cleared or froze the store would show stale or zero data on release, after a capture made under blanking.
- The bench also holds the strobe low across several edges, to catch a design that captures only on the falling transition and so misses the later words.

// File: rtl/pdp_latch_pkg.sv
// Shared types for the column output latch.
package pdp_latch_pkg;
    // Which source drives the column outputs.
    typedef enum logic [1:0] {
        OVR_NONE = 2'b00,   // stored pattern visible
        OVR_LOW  = 2'b01,   // blanked: all low
        OVR_HIGH = 2'b10    // forced: all high
    } ovr_sel_e;
endpackage

// File: rtl/pdp_stb_decode.sv
// Strobe decoder. Turns the strobe pin(s) into one capture enable.
// Assumes the pins are already synchronous to clk. In dual mode the pair
// counts only in its valid asserted state (primary low, partner high).
module pdp_stb_decode (
    input  logic mode_dual,
    input  logic stb_n,
    input  logic stb_pair,
    output logic capture_en
);
    // Purpose: select single-ended or paired strobe qualification.
    always_comb begin
        if (mode_dual)
            capture_en = !stb_n && stb_pair;
        else
            capture_en = !stb_n;
    end
endmodule

// File: rtl/pdp_hold_latch.sv
// Holding store. Loads the word on every edge that has capture_en high, so
// it is transparent while the strobe stays low and holds otherwise.
// Assumes a synchronous active-low reset.
module pdp_hold_latch #(
    parameter int WIDTH = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Purpose: capture on an asserted strobe, keep the value otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (capture_en)
            q <= d;
    end
endmodule

// File: rtl/pdp_ovr_select.sv
// Override priority. Blanking beats force, and force beats stored data.
module pdp_ovr_select
    import pdp_latch_pkg::*;
(
    input  logic     blank_n,
    input  logic     hv_force_n,
    output ovr_sel_e sel
);
    // Purpose: resolve the two-level override priority.
    always_comb begin
        if (!blank_n)
            sel = OVR_LOW;
        else if (!hv_force_n)
            sel = OVR_HIGH;
        else
            sel = OVR_NONE;
    end
endmodule

// File: rtl/pdp_out_mux.sv
// Per-bit output selector. It applies the override to the output vector only
// and never writes back into the store.
module pdp_out_mux
    import pdp_latch_pkg::*;
#(
    parameter int WIDTH = 192
) (
    input  ovr_sel_e         sel,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] y
);
    localparam int LAST = WIDTH - 1;

    for (genvar i = 0; i <= LAST; i++) begin : g_bit
        // Purpose: pick the forced level or the held bit for column i.
        always_comb begin
            unique case (sel)
                OVR_LOW:  y[i] = 1'b0;
                OVR_HIGH: y[i] = 1'b1;
                default:  y[i] = held[i];
            endcase
        end
    end
endmodule

// File: rtl/pdp_col_latch.sv
// Top of the strobed column output latch. The strobe is sampled on clk, and
// the overrides act combinationally on the outputs.
// Assumes every input is synchronous to clk.
module pdp_col_latch
    import pdp_latch_pkg::*;
#(
    parameter int WIDTH = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_dual,
    input  logic [WIDTH-1:0] col_data,
    input  logic             stb_n,
    input  logic             stb_pair,
    input  logic             blank_n,
    input  logic             hv_force_n,
    output logic [WIDTH-1:0] col_out
);
    logic             capture_en;
    logic [WIDTH-1:0] held;
    ovr_sel_e         sel;

    pdp_stb_decode u_dec (
        .mode_dual (mode_dual),
        .stb_n     (stb_n),
        .stb_pair  (stb_pair),
        .capture_en(capture_en)
    );

    pdp_hold_latch #(.WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_en(capture_en),
        .d         (col_data),
        .q         (held)
    );

    pdp_ovr_select u_ovr (
        .blank_n   (blank_n),
        .hv_force_n(hv_force_n),
        .sel       (sel)
    );

    pdp_out_mux #(.WIDTH(WIDTH)) u_mux (
        .sel (sel),
        .held(held),
        .y   (col_out)
    );
endmodule

// File: rtl/pdp_col_latch_chk.sv
// Checker for pdp_col_latch. It observes ports only, and is bound below.
module pdp_col_latch_chk #(
    parameter int WIDTH = 192
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_dual,
    input logic [WIDTH-1:0] col_data,
    input logic             stb_n,
    input logic             stb_pair,
    input logic             blank_n,
    input logic             hv_force_n,
    input logic [WIDTH-1:0] col_out
);
    logic strobe_on;
    logic clear_view;
    assign strobe_on  = mode_dual ? (!stb_n && stb_pair) : !stb_n;
    assign clear_view = blank_n && hv_force_n;

    p_blank_all_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> (col_out == '0));

    p_force_all_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && !hv_force_n) |-> (col_out == '1));

    p_capture_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_on |=> (!(blank_n && hv_force_n) || col_out == $past(col_data)));

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_on && clear_view) |=> (!(blank_n && hv_force_n) || $stable(col_out)));

    p_pair_invalid_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dual && (stb_n == stb_pair) && clear_view)
            |=> (!(blank_n && hv_force_n) || $stable(col_out)));
endmodule

bind pdp_col_latch pdp_col_latch_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_dual (mode_dual),
    .col_data  (col_data),
    .stb_n     (stb_n),
    .stb_pair  (stb_pair),
    .blank_n   (blank_n),
    .hv_force_n(hv_force_n),
    .col_out   (col_out)
);

// File: tb/pdp_col_latch_tb.sv
// Self-checking bench. It runs a near-exhaustive sweep over mode, strobe
// pins and overrides on a 16-column instance.
module pdp_col_latch_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_dual = 1'b0;
    logic [W-1:0] col_data = '0;
    logic         stb_n = 1'b1;
    logic         stb_pair = 1'b0;
    logic         blank_n = 1'b1;
    logic         hv_force_n = 1'b1;
    logic [W-1:0] col_out;

    int checks = 0;
    int errors = 0;
    logic         wd_hit = 1'b0;
    logic [W-1:0] model;     // expected stored pattern

    always #2 clk = ~clk;   // 250 MHz

    pdp_col_latch #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_dual(mode_dual), .col_data(col_data),
        .stb_n(stb_n), .stb_pair(stb_pair), .blank_n(blank_n),
        .hv_force_n(hv_force_n), .col_out(col_out)
    );

    function automatic logic [W-1:0] pat(input int k);
        return W'(k * 40503 + 12345) ^ W'(k << 3);
    endfunction

    function automatic logic strobe_exp(input logic md, input logic p, input logic m);
        return md ? (!p && m) : !p;     // R9 / R10 rule
    endfunction

    function automatic logic [W-1:0] out_exp(input logic [W-1:0] st);
        if (!blank_n) return '0;        // R5
        if (!hv_force_n) return '1;     // R6
        return st;                      // R7
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One rising edge: update the model, then settle on the falling edge.
    task automatic tick();
        @(posedge clk);
        if (!rst_n) model = '0;
        else if (strobe_exp(mode_dual, stb_n, stb_pair)) model = col_data;
        @(negedge clk);
    endtask

    task automatic run_all();
        logic [W-1:0] keep;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        chk("R1 reset clears", col_out, '0);

        // R2 / R3: strobe held low, output follows each word
        for (int i = 0; i < 6; i++) begin
            col_data = pat(i); stb_n = 1'b0;
            tick();
            chk(i == 0 ? "R2 capture" : "R3 transparent", col_out, pat(i));
        end
        // R4: released strobe holds
        stb_n = 1'b1; keep = pat(5);
        for (int i = 10; i < 14; i++) begin
            col_data = pat(i); tick();
            chk("R4 hold", col_out, keep);
        end
        // R9: partner pin ignored in single-ended mode
        for (int m = 0; m < 2; m++) begin
            stb_pair = m[0]; col_data = pat(20 + m); stb_n = 1'b1; tick();
            chk("R9 partner no capture", col_out, keep);
            stb_n = 1'b0; tick(); keep = pat(20 + m);
            chk("R9 partner no block", col_out, keep);
        end
        stb_n = 1'b1;
        // R8: capture under blanking survives release
        blank_n = 1'b0; col_data = pat(30); stb_n = 1'b0; tick();
        chk("R5 blanked during capture", col_out, '0);
        stb_n = 1'b1; col_data = pat(31); tick();
        blank_n = 1'b1; #1;
        chk("R8 restore after release", col_out, pat(30));
        // R5 priority over force
        blank_n = 1'b0; hv_force_n = 1'b0; #1;
        chk("R5 blank beats force", col_out, '0);
        blank_n = 1'b1; #1;
        chk("R6 force high", col_out, '1);
        hv_force_n = 1'b1; #1;
        chk("R8 store kept through force", col_out, pat(30));

        // Sweep: mode x stb_n x stb_pair x blank_n x hv_force_n
        for (int k = 0; k < 64; k++) begin
            mode_dual = k[0]; stb_n = k[1]; stb_pair = k[2];
            blank_n = k[3]; hv_force_n = k[4];
            col_data = pat(100 + k);
            tick();
            chk(mode_dual ? "R10 sweep" : "R7 sweep", col_out, out_exp(model));
            blank_n = 1'b1; hv_force_n = 1'b1; #1;
            chk("R8 sweep stored", col_out, model);
        end
        // R10 targeted: the invalid pair (0,0) must hold
        mode_dual = 1'b1; stb_n = 1'b1; stb_pair = 1'b1; col_data = pat(200); tick();
        keep = col_out;
        stb_n = 1'b0; stb_pair = 1'b0; col_data = pat(201); tick();
        chk("R10 pair 00 holds", col_out, keep);
        stb_pair = 1'b1; tick();
        chk("R10 pair valid captures", col_out, pat(201));
        // R1 again: reset mid-run
        stb_n = 1'b1; rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R1 reset mid-run", col_out, '0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule